// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one 32-bit timer channel with a small register bus. A prescaler turns the input clock into count ticks at one of four rates. The counter advances on each tick while the external start input is high. When the counter equals the compare register, the channel raises a match flag. In periodic mode the counter also falls back to zero, so one period spans compare+1 ticks. In free-running mode the counter runs on and raises an overflow flag when it wraps from all-ones to zero.

The match flag can drive an interrupt line or a DMA request, depending on a routing field. A separate enable bit drives a compare-output interrupt. Software loads a new counter value through the bus. The load lands a fixed number of clocks later, and a busy bit in the control/status word stays high until it has landed. Both flags are cleared by writing zero to their bit. Writing one leaves a flag as it is.

Top module: `tmr_cmp_channel`

## Requirements
- R1: After reset the control/status word (address 0) and the counter (address 1) read zero, the compare register (address 2) reads all-ones, and irq, dma_req and tout_irq are low.
- R2: Control bits 2:0 set the tick rate. Code 7 gives a tick every clock, 4 every 8 clocks, 5 every 32 clocks and 6 every 128 clocks, counting clocks from the first cycle with start high. Codes 0 to 3 give no ticks. The divider phase restarts while start is low and whenever the code changes.
- R3: The counter advances only while the start input is high. With start low it holds its value.
- R4: With control bit 8 set (periodic), a tick that finds the counter equal to the compare value sets the match flag (bit 15) and returns the counter to zero.
- R5: A write to the counter takes effect 3 clocks after the write edge. The busy bit (bit 13) reads 1 from the write until the load, and the old count is visible until then.
- R6: With bit 8 clear, the counter runs freely. A tick at all-ones wraps it to zero and sets the overflow flag (bit 14). A tick at the compare value still sets the match flag without resetting the counter.
- R7: Writing 0 to bit 15 or bit 14 clears that flag. Writing 1 leaves it unchanged. The writable fields (bits 8, 7, 5:4, 2:0) take the written value.
- R8: Bits 5:4 route the match: code 2 makes irq follow the match flag; code 1 raises dma_req on a match, held until a dma_ack pulse; code 0 raises neither.
- R9: With bit 7 set, tout_irq follows the match flag; with it clear, tout_irq stays low.
- R10: Writes to the control/status word and the compare register read back on the next clock. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control/status, 1 counter, 2 compare |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| start_i | input | 1 | Channel start (1 counts, 0 freezes) |
| dma_ack | input | 1 | Clears a pending DMA request |
| irq | output | 1 | Match interrupt (routing code 2) |
| dma_req | output | 1 | Match DMA request (routing code 1) |
| tout_irq | output | 1 | Compare-output interrupt |

## Verification
The counter is run in bursts of a known number of start-high clocks. Each stretch is sized to stop just short of a divider boundary or just past it, so an off-by-one in the prescaler or in the compare point shows up as a wrong count. The periodic and free-running runs share the same equality point but differ in what follows it, which tells a zero-restart apart from a wrap with overflow. The counter-load test reads the busy bit and the count on each clock after the write, which pins down the exact landing cycle. Flag writes with 1 and then with 0 separate write-one-no-effect from clear-on-zero, and the three routing codes are compared on all three request outputs.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

   typedef enum logic [1:0] {
      RT_NONE = 2'd0,
      RT_DMA  = 2'd1,
      RT_IRQ  = 2'd2,
      RT_RSVD = 2'd3
   } route_e;

   localparam int unsigned CSR_W      = 16;
   localparam int unsigned B_MATCH    = 15;
   localparam int unsigned B_OVF      = 14;
   localparam int unsigned B_BUSY     = 13;
   localparam int unsigned B_PERIODIC = 8;
   localparam int unsigned B_TOUT_IE  = 7;

   localparam logic [1:0] A_CSR = 2'd0;
   localparam logic [1:0] A_CNT = 2'd1;
   localparam logic [1:0] A_CMP = 2'd2;

   typedef struct packed {
      logic       periodic;
      logic       tout_ie;
      route_e     route;
      logic [2:0] rate;
   } ctl_t;

   // log2 of the divider for each rate code; valid codes have bit 2 set
   function automatic int unsigned rate_shift(input logic [2:0] code);
      case (code)
         3'd4:    return 3;
         3'd5:    return 5;
         3'd6:    return 7;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/tmr_cmp_presc.sv
module tmr_cmp_presc #(
   parameter int unsigned MAX_SH = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] rate,
   output logic       tick
);
   import tmr_cmp_pkg::*;

   localparam int unsigned PH_W = MAX_SH;

   if (MAX_SH < 7) begin : g_bad_sh
      $error("tmr_cmp_presc: MAX_SH must cover the /128 setting");
   end

   logic [PH_W-1:0] phase_q;
   logic [2:0]      rate_q;
   logic [PH_W-1:0] limit;
   logic            rate_ok;
   logic            rate_chg;

   assign rate_ok  = rate[2];
   assign rate_chg = (rate != rate_q);
   assign limit    = PH_W'((1 << rate_shift(rate)) - 1);
   assign tick     = run && rate_ok && !rate_chg && (phase_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         rate_q  <= '0;
      end else begin
         rate_q <= rate;
         if (!run || rate_chg || !rate_ok || phase_q == limit)
            phase_q <= '0;
         else
            phase_q <= phase_q + 1'b1;
      end
   end

   // R2: invalid codes never produce a tick
   a_r2_no_tick_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      !rate[2] |-> !tick);
   // R2: a rate change suppresses the next tick while the phase restarts
   a_r2_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (rate != $past(rate)) && rate != 3'd7 |-> !tick);

endmodule

// File: rtl/tmr_cmp_core.sv
module tmr_cmp_core #(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned BUSY_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             periodic,
   input  logic [CNT_W-1:0] cmp,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] cnt,
   output logic             busy,
   output logic             match_ev,
   output logic             ovf_ev
);
   localparam int unsigned BC_W = $clog2(BUSY_CYC + 1);

   if (BUSY_CYC < 2) begin : g_bad_busy
      $error("tmr_cmp_core: BUSY_CYC must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pend_val_q;
   logic [BC_W-1:0]  pend_q;
   logic             load;
   logic             step;
   logic             to_zero;

   assign load     = (pend_q == BC_W'(1));
   assign step     = tick && run && !load;
   assign match_ev = step && (cnt_q == cmp);
   assign to_zero  = match_ev && periodic;
   assign ovf_ev   = step && !to_zero && (&cnt_q);
   assign busy     = (pend_q != '0);
   assign cnt      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= '0;
         pend_val_q <= '0;
      end else if (cnt_wr) begin
         pend_q     <= BC_W'(BUSY_CYC);
         pend_val_q <= cnt_wdata;
      end else if (busy) begin
         pend_q <= pend_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load)    cnt_q <= pend_val_q;
      else if (to_zero) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_q + 1'b1;
   end

   a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !load |=> $stable(cnt_q));
   a_r4_periodic_zero: assert property (@(posedge clk) disable iff (!rst_n)
      match_ev && periodic |=> cnt_q == '0);
   a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> busy);
   a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      load && !cnt_wr |=> !busy && cnt_q == $past(pend_val_q));
   a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_ev |=> cnt_q == '0);

endmodule

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel #(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned BUSY_CYC = 3,
   parameter bit          HAS_DMA  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             start_i,
   input  logic             dma_ack,
   output logic             irq,
   output logic             dma_req,
   output logic             tout_irq
);
   import tmr_cmp_pkg::*;

   if (CNT_W < CSR_W) begin : g_bad_w
      $error("tmr_cmp_channel: CNT_W must hold the control/status word");
   end

   ctl_t             ctl_q;
   logic             match_q;
   logic             ovf_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] cnt;
   logic             busy;
   logic             match_ev;
   logic             ovf_ev;
   logic             tick;
   logic             csr_wr;
   logic [CSR_W-1:0] csr_rd;

   assign csr_wr = bus_wr && (bus_addr == A_CSR);

   tmr_cmp_presc #(.MAX_SH(7)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (start_i),
      .rate  (ctl_q.rate),
      .tick  (tick)
   );

   tmr_cmp_core #(.CNT_W(CNT_W), .BUSY_CYC(BUSY_CYC)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .run       (start_i),
      .periodic  (ctl_q.periodic),
      .cmp       (cmp_q),
      .cnt_wr    (bus_wr && bus_addr == A_CNT),
      .cnt_wdata (bus_wdata),
      .cnt       (cnt),
      .busy      (busy),
      .match_ev  (match_ev),
      .ovf_ev    (ovf_ev)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         cmp_q <= '1;
      end else begin
         if (csr_wr) begin
            ctl_q.periodic <= bus_wdata[B_PERIODIC];
            ctl_q.tout_ie  <= bus_wdata[B_TOUT_IE];
            ctl_q.route    <= route_e'(bus_wdata[5:4]);
            ctl_q.rate     <= bus_wdata[2:0];
         end
         if (bus_wr && bus_addr == A_CMP) cmp_q <= bus_wdata;
      end
   end

   // hardware set wins over a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (match_ev)                         match_q <= 1'b1;
         else if (csr_wr && !bus_wdata[B_MATCH]) match_q <= 1'b0;
         if (ovf_ev)                           ovf_q <= 1'b1;
         else if (csr_wr && !bus_wdata[B_OVF]) ovf_q <= 1'b0;
      end
   end

   always_comb begin
      csr_rd             = '0;
      csr_rd[B_MATCH]    = match_q;
      csr_rd[B_OVF]      = ovf_q;
      csr_rd[B_BUSY]     = busy;
      csr_rd[B_PERIODIC] = ctl_q.periodic;
      csr_rd[B_TOUT_IE]  = ctl_q.tout_ie;
      csr_rd[5:4]        = ctl_q.route;
      csr_rd[2:0]        = ctl_q.rate;
      case (bus_addr)
         A_CSR:   bus_rdata = CNT_W'(csr_rd);
         A_CNT:   bus_rdata = cnt;
         A_CMP:   bus_rdata = cmp_q;
         default: bus_rdata = '0;
      endcase
   end

   assign irq      = match_q && (ctl_q.route == RT_IRQ);
   assign tout_irq = match_q && ctl_q.tout_ie;

   if (HAS_DMA) begin : g_dma
      logic dma_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 dma_q <= 1'b0;
         else if (match_ev && ctl_q.route == RT_DMA) dma_q <= 1'b1;
         else if (dma_ack)                           dma_q <= 1'b0;
      end
      assign dma_req = dma_q;

      a_r8_dma_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
         dma_ack && !match_ev |=> !dma_req);
   end else begin : g_no_dma
      assign dma_req = 1'b0;
   end

   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      match_q && !csr_wr |=> match_q);
   a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      csr_wr && !bus_wdata[B_OVF] && !ovf_ev |=> !ovf_q);
   a_r8_irq_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> match_q);
   a_r6_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_ev |=> ovf_q);

endmodule

// File: tb/tmr_cmp_channel_bench.sv
`timescale 1ns/1ps
module tmr_cmp_channel_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        start_i = 1'b0;
   logic        dma_ack = 1'b0;
   logic        irq, dma_req, tout_irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // scoreboard: src 0..3 = register address, 4 irq, 5 dma_req, 6 tout_irq
   int          src_q[$];
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   tmr_cmp_channel u_tmr_cmp_channel (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start_i(start_i),
      .dma_ack(dma_ack), .irq(irq), .dma_req(dma_req), .tout_irq(tout_irq)
   );

   int          m_src;
   logic [31:0] m_exp;
   logic [31:0] m_act;
   string       m_tag;

   always @(negedge clk) begin
      if (src_q.size() > 0) begin
         m_src = src_q.pop_front();
         m_exp = exp_q.pop_front();
         m_tag = tag_q.pop_front();
         case (m_src)
            4:       m_act = {31'd0, irq};
            5:       m_act = {31'd0, dma_req};
            6:       m_act = {31'd0, tout_irq};
            default: m_act = bus_rdata;
         endcase
         checks++;
         if (m_act !== m_exp) begin
            failures++;
            $display("FAIL %s src=%0d actual=%h expected=%h", m_tag, m_src, m_act, m_exp);
         end
      end
   end

   task automatic chk(input int src, input logic [31:0] exp, input string tag);
      if (src < 4) bus_addr = 2'(src);
      src_q.push_back(src);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic run(input int n);
      start_i = 1'b1;
      repeat (n) begin @(posedge clk); #1; end
      start_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      chk(0, 32'h0, "R1 csr");
      chk(1, 32'h0, "R1 cnt");
      chk(2, 32'hFFFF_FFFF, "R1 cmp");
      chk(4, 0, "R1 irq");
      chk(5, 0, "R1 dma");
      chk(6, 0, "R1 tout");
      // R10 register write/readback
      wr(2, 32'd5);
      chk(2, 32'd5, "R10 cmp readback");
      wr(0, 32'h0127);
      chk(0, 32'h0127, "R10 csr readback");
      chk(3, 32'h0, "R10 addr3");
      // R3 stopped counter holds
      idle(5);
      chk(1, 32'h0, "R3 hold stopped");
      // R4 periodic, /1
      run(4);
      chk(1, 32'd4, "R4 before match");
      chk(0, 32'h0127, "R4 no match yet");
      run(3);
      chk(1, 32'd1, "R4 restart from zero");
      chk(0, 32'h8127, "R4 match flag");
      chk(4, 1, "R8 irq route 2");
      chk(6, 0, "R9 tout disabled");
      // R7 write-one keeps, write-zero clears
      wr(0, 32'hC127);
      chk(0, 32'h8127, "R7 write one keeps");
      wr(0, 32'h0127);
      chk(0, 32'h0127, "R7 write zero clears");
      chk(4, 0, "R8 irq follows flag");
      // R5 delayed counter load
      wr(1, 32'd100);
      chk(0, 32'h2127, "R5 busy set");
      chk(1, 32'd1, "R5 old value visible");
      chk(0, 32'h2127, "R5 busy still set");
      chk(1, 32'd100, "R5 value landed");
      chk(0, 32'h0127, "R5 busy cleared");
      // R6 free-running overflow and match
      wr(2, 32'd3);
      wr(0, 32'h0097);
      wr(1, 32'hFFFF_FFFE);
      idle(4);
      run(3);
      chk(1, 32'd1, "R6 wrapped");
      chk(0, 32'h4097, "R6 overflow flag");
      run(3);
      chk(1, 32'd4, "R6 no restart on match");
      chk(0, 32'hC097, "R6 match flag");
      chk(5, 1, "R8 dma route 1");
      chk(4, 0, "R8 no irq on route 1");
      chk(6, 1, "R9 tout enabled");
      dma_ack = 1'b1; idle(1); dma_ack = 1'b0;
      chk(5, 0, "R8 dma_ack clears");
      chk(0, 32'hC097, "R8 ack keeps flag");
      wr(0, 32'h8097);
      chk(0, 32'h8097, "R7 clear overflow only");
      wr(0, 32'h0097);
      chk(6, 0, "R9 tout after clear");
      // R2 prescaler rates
      wr(0, 32'h0004);
      wr(1, 32'd0);
      idle(4);
      run(15);
      chk(1, 32'd1, "R2 div8 one tick");
      run(16);
      chk(1, 32'd3, "R2 div8 two ticks");
      wr(0, 32'h0005);
      wr(1, 32'd0);
      idle(4);
      run(64);
      chk(1, 32'd2, "R2 div32");
      wr(0, 32'h0006);
      wr(1, 32'd0);
      idle(4);
      run(255);
      chk(1, 32'd1, "R2 div128");
      wr(0, 32'h0000);
      run(20);
      chk(1, 32'd1, "R2 code0 no ticks");
      // R8 route 0
      wr(0, 32'h0107);
      wr(1, 32'd0);
      idle(4);
      run(5);
      chk(0, 32'h8107, "R8 route0 flag");
      chk(4, 0, "R8 route0 irq");
      chk(5, 0, "R8 route0 dma");
      idle(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule